// File: doc/BRIEF.md
# Serial SAR Converter Host Sequencer

This block runs one complete transaction with an external 4-wire successive-approximation converter that times its own conversion. A one-cycle start request carries a channel number, a polarity flag, an input-mode flag and a two-bit power setting. The sequencer pulls chip select low and shifts a command byte out on the data-out wire. It then holds the serial clock still while the converter samples and converts. Next it clocks a 16-bit read frame and returns the 12-bit sample with a one-cycle valid strobe.

The serial clock comes from the system clock through a parameterized divider. A guard counter holds the serial clock low for a minimum number of system clocks after the command byte, so a faster serial clock can be used safely. The converter's busy strobe, low while it converts, passes through a synchronizer and decides when the read may begin. If the strobe does not come back in time, the transaction ends with a timeout pulse.

Top module: `sar_adc_host`

## Requirements
- R1: After reset and whenever no transaction is active, chip select (`cs_n_o`) is high, `sclk_o` is low, and `valid_o` and `timeout_o` are low. `sclk_o` is never high while `cs_n_o` is high.
- R2: A start pulse in idle drives `cs_n_o` low and sends an 8-bit command, most significant bit first, as {1, chan[2:0], unipolar, single, pd[1:0]}. Bit 7 is a constant 1, bits 6:4 are the channel, bit 3 is the unipolar flag, bit 2 is the single-ended flag and bits 1:0 are the power setting. `din_o` changes only while `sclk_o` is low and is steady across every rising edge.
- R3: While the sequencer is clocking, each high phase and each low phase of `sclk_o` between pulses lasts exactly HALF_DIV system clocks.
- R4: After the eighth falling edge of the command, `sclk_o` stays low for at least ACQ_CYCLES system clocks, even if the converter finishes sooner.
- R5: While the converter is busy (strobe low, after the command), `sclk_o` makes no edge and `cs_n_o` stays low.
- R6: The read frame starts only after the strobe has been seen low and then high again. The frame consists of exactly 16 `sclk_o` pulses.
- R7: `dout_i` is captured on the rising edge that follows each falling edge. The first 12 captures form the result, most significant bit first, and the trailing zero bits are discarded.
- R8: At the end of a frame, `data_o` carries the result and `valid_o` is high for exactly one cycle, in the same cycle that `cs_n_o` returns high.
- R9: If the strobe has not returned high within TIMEOUT_CYCLES system clocks after the command, `timeout_o` pulses for one cycle, `cs_n_o` goes high and no `valid_o` follows.
- R10: A start pulse that arrives during a transaction is ignored: it starts no new frame and produces no extra result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to run a transaction |
| chan_i | input | 3 | Channel select placed in the command |
| unipolar_i | input | 1 | Unipolar (1) or bipolar (0) coding flag |
| single_i | input | 1 | Single-ended (1) or differential (0) flag |
| pd_i | input | 2 | Power-down setting placed in the command |
| sclk_o | output | 1 | Serial clock to the converter |
| cs_n_o | output | 1 | Active-low chip select |
| din_o | output | 1 | Command bit to the converter |
| sstrb_i | input | 1 | Converter busy strobe, low while converting |
| dout_i | input | 1 | Result bit from the converter |
| data_o | output | 12 | Captured sample |
| valid_o | output | 1 | One-cycle strobe marking `data_o` as new |
| timeout_o | output | 1 | One-cycle pulse when the strobe stays low too long |

## Verification
The bench builds the block with HALF_DIV=2, ACQ_CYCLES=20, TIMEOUT_CYCLES=200 and a two-stage strobe synchronizer. At these values the pulse widths of every clock phase can be counted exactly, and the timeout fires within a couple of hundred cycles. In one case a converter model finishes in 3 cycles, well inside the acquisition guard, to show that the guard alone holds the read back. Another case holds the strobe low indefinitely to check the timeout path and the recovery that follows.

// File: rtl/sar_host_pkg.sv
// Package: shared types and helpers for the serial converter host sequencer.
// Assumes: a command byte of 8 bits with the start marker in the top bit.
package sar_host_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_CONV = 2'd2,
        ST_RX   = 2'd3
    } host_st_t;

    localparam int CMD_BITS = 8;

    // Assemble the command byte, start marker first.
    function automatic logic [CMD_BITS-1:0] make_cmd(
        input logic [2:0] chan,
        input logic       unipolar,
        input logic       single,
        input logic [1:0] pd
    );
        return {1'b1, chan, unipolar, single, pd};
    endfunction

endpackage

// File: rtl/sar_sync.sv
// Module: sar_sync - multi-stage synchronizer for an asynchronous level.
// Assumes: the input is a slow level; STAGES >= 1; resets to RST_VAL.
module sar_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture register.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_many
            // Shift the level through the register chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sar_sclk_div.sv
// Module: sar_sclk_div - emits a tick every HALF_DIV system clocks while run is high.
// Assumes: the counter restarts from zero each time run rises, so the first
// tick comes a full half period after the run starts.
module sar_sclk_div #(
    parameter int HALF_DIV = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_DIV - 1));

    // Count system clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    generate
        if (HALF_DIV > 1) begin : g_chk
            assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/sar_conv_timer.sv
// Module: sar_conv_timer - times the wait between the command and the read.
// Reports when the acquisition guard has elapsed, whether the busy strobe was
// seen low, and when the wait limit is reached.
// Assumes: TIMEOUT_CYCLES > ACQ_CYCLES; everything clears while active is low.
module sar_conv_timer #(
    parameter int ACQ_CYCLES     = 75,
    parameter int TIMEOUT_CYCLES = 380
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic strobe,
    output logic acq_done,
    output logic seen_low,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);

    logic [CW-1:0] cnt;

    assign acq_done = (cnt >= CW'(ACQ_CYCLES));
    assign expired  = (cnt >= CW'(TIMEOUT_CYCLES));

    // Saturating count of cycles spent waiting.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) cnt <= '0;
        else if (!expired)     cnt <= cnt + 1'b1;
    end

    // Remember that the converter has signalled busy.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) seen_low <= 1'b0;
        else if (!strobe)      seen_low <= 1'b1;
    end

    assert_seen_needs_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !seen_low && strobe) |=> !seen_low);
endmodule

// File: rtl/sar_adc_host.sv
// Module: sar_adc_host - host sequencer for a serial SAR converter that times
// its own conversion. It sends the command, waits on the busy strobe with the
// serial clock parked low, reads a frame and returns the sample.
// Assumes: FRAME_CLKS > DATA_W; dout_i settles within one half period of a
// falling sclk edge; sstrb_i is asynchronous and is synchronized here.
module sar_adc_host
    import sar_host_pkg::*;
#(
    parameter int HALF_DIV       = 13,
    parameter int ACQ_CYCLES     = 75,
    parameter int TIMEOUT_CYCLES = 380,
    parameter int DATA_W         = 12,
    parameter int FRAME_CLKS     = 16,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        chan_i,
    input  logic              unipolar_i,
    input  logic              single_i,
    input  logic [1:0]        pd_i,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic              din_o,
    input  logic              sstrb_i,
    input  logic              dout_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              timeout_o
);
    localparam int TX_CW    = $clog2(CMD_BITS);
    localparam int FRAME_CW = $clog2(FRAME_CLKS);

    host_st_t            st;
    logic [CMD_BITS-1:0] tx_sh;
    logic [TX_CW-1:0]    tx_cnt;
    logic [DATA_W-1:0]   rx_sh;
    logic [FRAME_CW-1:0] rx_cnt;
    logic                tick;
    logic                strobe_s;
    logic                acq_done;
    logic                seen_low;
    logic                expired;
    logic                sample_now;
    logic [CMD_BITS-1:0] cmd_byte;

    assign cmd_byte   = make_cmd(chan_i, unipolar_i, single_i, pd_i);
    assign sample_now = (rx_cnt != '0) && (rx_cnt <= FRAME_CW'(DATA_W));

    sar_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   ((st == ST_TX) || (st == ST_RX)),
        .tick  (tick)
    );

    sar_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sstrb_i),
        .q     (strobe_s)
    );

    sar_conv_timer #(.ACQ_CYCLES(ACQ_CYCLES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (st == ST_CONV),
        .strobe   (strobe_s),
        .acq_done (acq_done),
        .seen_low (seen_low),
        .expired  (expired)
    );

    // Transaction sequencer: command, guarded wait, read frame, result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            sclk_o    <= 1'b0;
            cs_n_o    <= 1'b1;
            din_o     <= 1'b0;
            tx_sh     <= '0;
            tx_cnt    <= '0;
            rx_sh     <= '0;
            rx_cnt    <= '0;
            data_o    <= '0;
            valid_o   <= 1'b0;
            timeout_o <= 1'b0;
        end else begin
            valid_o   <= 1'b0;
            timeout_o <= 1'b0;
            case (st)
                ST_IDLE: begin
                    sclk_o <= 1'b0;
                    if (start_i) begin
                        cs_n_o <= 1'b0;
                        din_o  <= cmd_byte[CMD_BITS-1];
                        tx_sh  <= cmd_byte << 1;
                        tx_cnt <= '0;
                        st     <= ST_TX;
                    end
                end
                ST_TX: begin
                    if (tick) begin
                        if (!sclk_o) begin
                            sclk_o <= 1'b1;
                        end else begin
                            sclk_o <= 1'b0;
                            if (tx_cnt == TX_CW'(CMD_BITS - 1)) begin
                                din_o <= 1'b0;
                                st    <= ST_CONV;
                            end else begin
                                tx_cnt <= tx_cnt + 1'b1;
                                din_o  <= tx_sh[CMD_BITS-1];
                                tx_sh  <= tx_sh << 1;
                            end
                        end
                    end
                end
                ST_CONV: begin
                    if (acq_done && seen_low && strobe_s) begin
                        rx_cnt <= '0;
                        rx_sh  <= '0;
                        st     <= ST_RX;
                    end else if (expired) begin
                        timeout_o <= 1'b1;
                        cs_n_o    <= 1'b1;
                        st        <= ST_IDLE;
                    end
                end
                ST_RX: begin
                    if (tick) begin
                        if (!sclk_o) begin
                            sclk_o <= 1'b1;
                            if (sample_now) rx_sh <= {rx_sh[DATA_W-2:0], dout_i};
                        end else begin
                            sclk_o <= 1'b0;
                            if (rx_cnt == FRAME_CW'(FRAME_CLKS - 1)) begin
                                cs_n_o  <= 1'b1;
                                valid_o <= 1'b1;
                                data_o  <= rx_sh;
                                st      <= ST_IDLE;
                            end else begin
                                rx_cnt <= rx_cnt + 1'b1;
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_idle_sclk_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);
    assert_din_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TX && $rose(sclk_o)) |-> $stable(din_o));
    assert_acq_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CONV && !acq_done) |=> (st != ST_RX));
    assert_quiet_conv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CONV) |-> (!sclk_o && !cs_n_o));
    assert_read_after_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CONV && !strobe_s) |=> (st != ST_RX));
    assert_valid_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    assert_valid_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> cs_n_o);
    assert_timeout_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!valid_o && cs_n_o));
endmodule

// File: tb/sim_sar_adc_host.sv
// Bench: scoreboard around a behavioural converter model.
module sim_sar_adc_host;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int ACQ        = 20;
    localparam int TMO        = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  chan = '0;
    logic        uni = 1'b0;
    logic        sgl = 1'b0;
    logic [1:0]  pd = '0;
    logic        sclk_o, cs_n_o, din_o, valid_o, timeout_o;
    logic        sstrb = 1'b1;
    logic        dout = 1'b0;
    logic [11:0] data_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_adc_host #(.HALF_DIV(HALF), .ACQ_CYCLES(ACQ), .TIMEOUT_CYCLES(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .chan_i(chan),
        .unipolar_i(uni), .single_i(sgl), .pd_i(pd),
        .sclk_o(sclk_o), .cs_n_o(cs_n_o), .din_o(din_o),
        .sstrb_i(sstrb), .dout_i(dout),
        .data_o(data_o), .valid_o(valid_o), .timeout_o(timeout_o));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Bench-driven model settings.
    logic [11:0] m_sample = '0;
    int          m_conv_len = 60;
    bit          m_hold = 1'b0;

    // Model state and observations.
    logic [7:0]  m_ctrl = '0;
    int m_phase = 0, m_ncmd = 0, m_d = 0, m_c = 0, m_bit = 0;
    int m_rx_rises = 0, m_gap = 0, m_t8 = 0, m_frames = 0;
    int m_edge_viol = 0, m_width_err = 0, m_hi = 0, m_lo = 0;
    bit m_first = 1'b0, m_prev = 1'b0, m_cs_prev = 1'b1;

    // Converter model: reacts to the sequencer's pins at the falling clk edge.
    always @(negedge clk) begin
        bit rise, fall;
        rise = sclk_o && !m_prev;
        fall = !sclk_o && m_prev;
        m_prev = sclk_o;
        if (m_cs_prev && !cs_n_o) begin
            m_phase = 1; m_ncmd = 0; m_rx_rises = 0; m_frames++; m_lo = 0;
        end
        m_cs_prev = cs_n_o;
        if (rise) begin
            if (m_phase == 1 && m_ncmd > 0 && m_lo != HALF) m_width_err++;
            m_lo = 0; m_hi = 1;
        end else if (fall) begin
            if (m_hi != HALF) m_width_err++;
            m_hi = 0; m_lo = 1;
        end else if (sclk_o) m_hi++;
        else m_lo++;
        case (m_phase)
            1: begin
                if (rise) begin m_ctrl = {m_ctrl[6:0], din_o}; m_ncmd++; end
                if (fall && m_ncmd == 8) begin m_phase = 2; m_t8 = cyc; m_d = 0; end
            end
            2: begin
                m_d++;
                if (m_d == 2) begin sstrb = 1'b0; m_phase = 3; m_c = 0; end
            end
            3: begin
                if (rise || fall) m_edge_viol++;
                m_c++;
                if (!m_hold && m_c >= m_conv_len) begin
                    sstrb = 1'b1; m_phase = 4; m_bit = 0; m_first = 1'b1;
                end
            end
            4: begin
                if (fall) begin
                    dout = (m_bit < 12) ? m_sample[11 - m_bit] : 1'b0;
                    m_bit++;
                end
                if (rise) begin
                    m_rx_rises++;
                    if (m_first) begin m_gap = cyc - m_t8; m_first = 1'b0; end
                end
            end
            default: ;
        endcase
    end

    // Scoreboard storage: driver writes, monitor reads.
    logic [19:0] exp_mem [16];
    int wr_ptr = 0;
    int rd_ptr = 0;
    int mon_tests = 0, mon_fail = 0;
    int n_tests = 0, n_fail = 0;

    task automatic mcheck(input bit ok, input string req, input int act, input int exp);
        mon_tests++;
        if (!ok) begin
            mon_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compare each produced result with the oldest expected item.
    always @(negedge clk) begin
        if (valid_o) begin
            if (rd_ptr == wr_ptr) begin
                mcheck(1'b0, "R10 unexpected result", int'(data_o), -1);
            end else begin
                logic [19:0] e;
                e = exp_mem[rd_ptr % 16];
                rd_ptr++;
                mcheck(data_o == e[11:0], "R7 sample value", int'(data_o), int'(e[11:0]));
                mcheck(m_ctrl == e[19:12], "R2 command byte", int'(m_ctrl), int'(e[19:12]));
                mcheck(m_rx_rises == 16, "R6 read frame pulses", m_rx_rises, 16);
                mcheck(m_gap >= ACQ, "R4 acquisition guard", m_gap, ACQ);
                mcheck(cs_n_o == 1'b1, "R8 cs high with valid", int'(cs_n_o), 1);
            end
        end
    end

    task automatic pulse_start(input logic [2:0] c, input logic u, input logic s, input logic [1:0] p);
        @(negedge clk);
        chan = c; uni = u; sgl = s; pd = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_valid(output bit got);
        got = 1'b0;
        for (int i = 0; i < 3000 && !got; i++) begin
            @(negedge clk);
            if (valid_o) got = 1'b1;
        end
    endtask

    // Driver: push the expected item, launch, await the result.
    task automatic run_conv(input logic [2:0] c, input logic u, input logic s,
                            input logic [1:0] p, input logic [11:0] smp, input int clen);
        bit got;
        int v0, w0;
        v0 = m_edge_viol; w0 = m_width_err;
        m_sample = smp; m_conv_len = clen;
        exp_mem[wr_ptr % 16] = {1'b1, c, u, s, p, smp};
        wr_ptr++;
        pulse_start(c, u, s, p);
        wait_valid(got);
        check(got, "R8 valid produced", int'(got), 1);
        @(negedge clk);
        check(valid_o == 1'b0, "R8 valid one cycle", int'(valid_o), 0);
        check(cs_n_o && !sclk_o, "R1 idle after frame", int'({cs_n_o, sclk_o}), 2);
        check(m_edge_viol == v0, "R5 sclk quiet while busy", m_edge_viol - v0, 0);
        check(m_width_err == w0, "R3 sclk phase widths", m_width_err - w0, 0);
    endtask

    task automatic run_all();
        bit got;
        int f0, t0, ttm;
        bit seen_to;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(cs_n_o == 1'b1, "R1 reset cs", int'(cs_n_o), 1);
        check(sclk_o == 1'b0, "R1 reset sclk", int'(sclk_o), 0);
        check(!valid_o && !timeout_o, "R1 reset strobes", int'({valid_o, timeout_o}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_conv(3'd0, 1'b1, 1'b1, 2'b11, 12'hFFF, 60);
        run_conv(3'd5, 1'b0, 1'b1, 2'b01, 12'h000, 60);
        run_conv(3'd2, 1'b1, 1'b0, 2'b10, 12'hA5A, 40);
        run_conv(3'd7, 1'b0, 1'b0, 2'b00, 12'h5A5, 80);
        // Converter faster than the guard: read must still wait (R4).
        run_conv(3'd6, 1'b1, 1'b1, 2'b11, 12'h801, 3);

        // Start during a busy transaction is ignored (R10).
        f0 = m_frames;
        m_sample = 12'h3C6; m_conv_len = 60;
        exp_mem[wr_ptr % 16] = {1'b1, 3'd4, 1'b1, 1'b0, 2'b01, 12'h3C6};
        wr_ptr++;
        pulse_start(3'd4, 1'b1, 1'b0, 2'b01);
        repeat (30) @(negedge clk);
        pulse_start(3'd1, 1'b0, 1'b1, 2'b10);
        wait_valid(got);
        check(got, "R10 first request completes", int'(got), 1);
        repeat (150) @(negedge clk);
        check(m_frames == f0 + 1, "R10 no extra frame", m_frames - f0, 1);

        // Strobe stuck low: timeout path (R9).
        m_hold = 1'b1;
        f0 = m_frames;
        t0 = rd_ptr;
        pulse_start(3'd3, 1'b1, 1'b1, 2'b00);
        seen_to = 1'b0;
        ttm = 0;
        for (int i = 0; i < 1000 && !seen_to; i++) begin
            @(negedge clk);
            if (timeout_o) begin seen_to = 1'b1; ttm = cyc - m_t8; end
        end
        check(seen_to, "R9 timeout raised", int'(seen_to), 1);
        check(ttm >= TMO && ttm <= TMO + 4, "R9 timeout delay", ttm, TMO);
        @(negedge clk);
        check(timeout_o == 1'b0, "R9 timeout one cycle", int'(timeout_o), 0);
        check(cs_n_o == 1'b1, "R9 cs released", int'(cs_n_o), 1);
        m_hold = 1'b0;
        repeat (100) @(negedge clk);
        check(rd_ptr == t0, "R9 no result after timeout", rd_ptr - t0, 0);
        check(m_frames == f0 + 1, "R9 single frame", m_frames - f0, 1);

        // Recovery after timeout.
        run_conv(3'd1, 1'b0, 1'b1, 2'b10, 12'h9E7, 50);
        check(rd_ptr == wr_ptr, "R8 all results seen", rd_ptr, wr_ptr);
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) check(1'b0, "watchdog", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests + mon_tests, n_fail + mon_fail);
        $finish;
    end
endmodule